// File: doc/BRIEF.md
# Cycle Counter with Latched Compare Interrupts

This block keeps a free-running cycle counter that advances by one on every clock, together with a small bank of compare channels. Each channel holds a value; when the counter equals it, the channel latches an interrupt request. The counter still moves on, so the equality lasts only one cycle, but the request stays high until software rewrites that channel's compare value. An external interrupt controller sees one request line per channel.

A second counter counts each rollover of the low counter. Software reads `{wrap, count}` to form a 64-bit cycle value. A compare value of zero therefore gives one request per rollover, which can serve as an overflow tick. Software reaches the counter, the wrap count and the compare values through a plain write port and a combinational read port.

Top module: `cyc_timer`

## Requirements
- R1: While reset is asserted, and right after it, the count, the wrap count, every compare value and every request read as zero. Reset asserts asynchronously and releases on a clock edge.
- R2: Except on a counter write, the count rises by one per clock and goes from 0xFFFFFFFF to 0.
- R3: The wrap count (read address 1) rises by one in the same edge that takes the count from 0xFFFFFFFF to 0, and only then. Writes to address 1 are ignored.
- R4: When the count equals the compare value of channel i, `irq[i]` is high from the next cycle. A channel whose value does not match stays low.
- R5: Once set, a request stays high after the count has moved past the matching value.
- R6: A write to channel i's compare address clears `irq[i]` on the next edge. Writes to the counter, the wrap address or an unused address leave every request unchanged.
- R7: If a write to channel i's compare address lands on the same edge as a match on channel i, the request stays set.
- R8: A compare value of 0 raises its request once per counter rollover. Because reset leaves both the count and the compares at 0, every channel asserts shortly after reset is released.
- R9: A write to address 0 loads the count on the next edge, with no increment in that cycle. A load taken while the count is 0xFFFFFFFF does not advance the wrap count.
- R10: Address map: 0 is the count, 1 is the wrap count, and 4+i is the compare value of channel i (read and write). Reads of addresses 2 and 3 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the counter advances on each rising edge |
| rst_n | input | 1 | Active-low reset: asserts asynchronously, releases synchronously |
| wr_en | input | 1 | Write strobe, taken at the rising edge |
| wr_addr | input | ADDR_W (3) | Write address |
| wr_data | input | CNT_W (32) | Write data |
| rd_addr | input | ADDR_W (3) | Read address |
| rd_data | output | CNT_W (32) | Combinational read data |
| irq | output | N_CMP (4) | Latched request, one bit per compare channel |

## Verification
If a compare register or the match logic is wrong, the request line comes up one cycle early, one cycle late, or never. The bench therefore samples each request in the cycle just before the expected edge and in the cycle just after it. A wrong latch state shows up at the ports when a request drops while the count keeps moving, or when a request survives the compare write that should clear it. An error in the wrap counter shows in the read-back value on the edge where the count rolls over. A missing or extra load cycle in the counter shows as an off-by-one count directly after a counter write.

// File: rtl/cyc_pkg.sv
package cyc_pkg;
  localparam int ADDR_CNT  = 0;
  localparam int ADDR_WRAP = 1;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_CNT,
    SEL_WRAP,
    SEL_CMP
  } rd_sel_e;
endpackage

// File: rtl/cyc_rst_sync.sv
module cyc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb stage_d = {stage_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= stage_d;
  end

  assign rst_sn = stage_q[1];
endmodule

// File: rtl/cyc_counter.sv
module cyc_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  output logic [W-1:0] cnt,
  output logic [W-1:0] wrap
);
  localparam logic [W-1:0] TOP = {W{1'b1}};
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] cnt_q, cnt_d;
  logic [W-1:0] wrap_q, wrap_d;
  logic         roll;

  always_comb begin
    roll   = !ld && (cnt_q == TOP);
    cnt_d  = ld ? ld_val : (cnt_q + ONE);
    wrap_d = wrap_q + ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    wrap_q <= '0;
    else if (roll) wrap_q <= wrap_d;
  end

  assign cnt  = cnt_q;
  assign wrap = wrap_q;

  // R2: free increment
  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !ld |=> cnt_q == $past(cnt_q) + ONE);
  // R9: load takes the written value
  p_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> cnt_q == $past(ld_val));
  // R3: rollover advances wrap together with count reaching zero
  p_roll_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld && cnt_q == TOP) |=> (cnt_q == '0 && wrap_q == $past(wrap_q) + ONE));
  // R3: wrap holds otherwise
  p_wrap_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(!ld && cnt_q == TOP) |=> $stable(wrap_q));
endmodule

// File: rtl/cyc_cmp_chan.sv
module cyc_cmp_chan #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] cnt,
  output logic [W-1:0] cmp_val,
  output logic         irq
);
  logic [W-1:0] cmp_q;
  logic         irq_q, irq_d;
  logic         match;

  always_comb begin
    match = (cnt == cmp_q);
    // a match on the same edge as a rewrite keeps the request
    irq_d = match | (irq_q & ~we);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cmp_q <= '0;
    else if (we) cmp_q <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign cmp_val = cmp_q;
  assign irq     = irq_q;

  // R4: equality raises the request one cycle later
  p_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    match |=> irq_q);
  // R4: no request without a match
  p_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_q && !match) |=> !irq_q);
  // R5: request is sticky while its compare is untouched
  p_latch_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && !we) |=> irq_q);
  // R6: compare rewrite without a match clears
  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !match) |=> !irq_q);
  // R7: rewrite colliding with a match leaves it set
  p_collide_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (we && match) |=> irq_q);
endmodule

// File: rtl/cyc_regif.sv
module cyc_regif #(
  parameter int W      = 32,
  parameter int N      = 4,
  parameter int ADDR_W = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [W-1:0]        wr_data,
  input  logic [ADDR_W-1:0]   rd_addr,
  input  logic [W-1:0]        cnt,
  input  logic [W-1:0]        wrap,
  input  logic [N-1:0][W-1:0] cmp_vals,
  output logic                cnt_ld,
  output logic [N-1:0]        cmp_we,
  output logic [W-1:0]        rd_data
);
  import cyc_pkg::*;

  localparam int OFF_W = ADDR_W - 1;
  localparam logic [ADDR_W-1:0] A_CNT  = ADDR_W'(ADDR_CNT);
  localparam logic [ADDR_W-1:0] A_WRAP = ADDR_W'(ADDR_WRAP);
  localparam logic [ADDR_W-1:0] N_A    = ADDR_W'(N);

  // compare block lives in the upper half of the address space
  always_comb cnt_ld = wr_en && (wr_addr == A_CNT);

  for (genvar i = 0; i < N; i++) begin : g_we
    localparam logic [OFF_W-1:0] OFF = OFF_W'(i);
    always_comb cmp_we[i] = wr_en && wr_addr[ADDR_W-1] && (wr_addr[OFF_W-1:0] == OFF);
  end

  rd_sel_e          rsel;
  logic [OFF_W-1:0] roff;

  always_comb begin
    roff = rd_addr[OFF_W-1:0];
    if (rd_addr == A_CNT)                                  rsel = SEL_CNT;
    else if (rd_addr == A_WRAP)                            rsel = SEL_WRAP;
    else if (rd_addr[ADDR_W-1] && ({1'b0, roff} < N_A))    rsel = SEL_CMP;
    else                                                   rsel = SEL_NONE;
  end

  always_comb begin
    rd_data = '0;
    case (rsel)
      SEL_CNT:  rd_data = cnt;
      SEL_WRAP: rd_data = wrap;
      SEL_CMP: begin
        for (int k = 0; k < N; k++)
          if (OFF_W'(k) == roff) rd_data = cmp_vals[k];
      end
      default:  rd_data = '0;
    endcase
  end

  // R6: a single write never touches both the counter and a compare
  p_one_target_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmp_we, cnt_ld}));
  // R10: an unused address never reads non-zero
  p_unused_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsel == SEL_NONE) |-> (rd_data == '0));
endmodule

// File: rtl/cyc_timer.sv
module cyc_timer #(
  parameter int CNT_W  = 32,
  parameter int N_CMP  = 4,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [CNT_W-1:0]  rd_data,
  output logic [N_CMP-1:0]  irq
);
  logic                      rst_sn;
  logic                      cnt_ld;
  logic [N_CMP-1:0]          cmp_we;
  logic [CNT_W-1:0]          cnt, wrap;
  logic [N_CMP-1:0][CNT_W-1:0] cmp_vals;

  cyc_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_sn (rst_sn)
  );

  cyc_counter #(.W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_sn),
    .ld     (cnt_ld),
    .ld_val (wr_data),
    .cnt    (cnt),
    .wrap   (wrap)
  );

  for (genvar i = 0; i < N_CMP; i++) begin : g_ch
    cyc_cmp_chan #(.W(CNT_W)) u_ch (
      .clk     (clk),
      .rst_n   (rst_sn),
      .we      (cmp_we[i]),
      .wdata   (wr_data),
      .cnt     (cnt),
      .cmp_val (cmp_vals[i]),
      .irq     (irq[i])
    );
  end

  cyc_regif #(.W(CNT_W), .N(N_CMP), .ADDR_W(ADDR_W)) u_reg (
    .clk      (clk),
    .rst_n    (rst_sn),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .rd_addr  (rd_addr),
    .cnt      (cnt),
    .wrap     (wrap),
    .cmp_vals (cmp_vals),
    .cnt_ld   (cnt_ld),
    .cmp_we   (cmp_we),
    .rd_data  (rd_data)
  );

  // R1: requests are low while reset is held
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_sn |-> (irq == '0));
endmodule

// File: tb/sim_cyc_timer.sv
`timescale 1ns/1ps
module sim_cyc_timer;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [2:0]  wr_addr;
  logic [31:0] wr_data;
  logic [2:0]  rd_addr;
  logic [31:0] rd_data;
  logic [3:0]  irq;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  cyc_timer u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // called at a negedge; returns at the negedge after the write edge
  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    rd_addr = a;
    #0.5;
    d = rd_data;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    tick(3);
    rd(3'd0, v); chk("R1 count in reset", v, 0);
    rd(3'd1, v); chk("R1 wrap in reset", v, 0);
    rd(3'd5, v); chk("R1 compare in reset", v, 0);
    chk("R1 irq in reset", {28'd0, irq}, 0);
    rst_n = 1'b1;
    tick(6);
    chk("R8 all channels fire after reset", {28'd0, irq}, 32'hF);
    for (int i = 0; i < 4; i++) wr(3'(4 + i), 32'h8000_0000 + i);
    chk("R6 compare writes clear all", {28'd0, irq}, 0);
  endtask

  task automatic t_count;
    logic [31:0] a, b, w0;
    wr(3'd0, 32'h1234_0000);
    rd(3'd0, a); chk("R9 load value, no increment", a, 32'h1234_0000);
    tick(1);
    rd(3'd0, b); chk("R2 increments by one", b, 32'h1234_0001);
    rd(3'd1, w0);
    wr(3'd0, 32'hFFFF_FFFE);
    tick(1);
    rd(3'd0, a); chk("R2 reaches top", a, 32'hFFFF_FFFF);
    rd(3'd1, b); chk("R3 wrap before roll", b, w0);
    tick(1);
    rd(3'd0, a); chk("R2 rolls to zero", a, 0);
    rd(3'd1, b); chk("R3 wrap after roll", b, w0 + 1);
    wr(3'd1, 32'h55);
    rd(3'd1, b); chk("R3 wrap write ignored", b, w0 + 1);
    wr(3'd0, 32'hFFFF_FFFF);
    wr(3'd0, 32'd100);
    rd(3'd0, a); chk("R9 load over top", a, 32'd100);
    rd(3'd1, b); chk("R9 load over top keeps wrap", b, w0 + 1);
  endtask

  task automatic t_match;
    wr(3'd4, 32'h200);
    wr(3'd0, 32'h1F0);
    tick(16);
    chk("R4 not yet set at equality cycle", {28'd0, irq}, 0);
    tick(1);
    chk("R4 only channel 0 set", {28'd0, irq}, 32'h1);
    tick(20);
    chk("R5 request held", {31'd0, irq[0]}, 1);
    wr(3'd0, 32'h50);
    chk("R6 counter write keeps request", {31'd0, irq[0]}, 1);
    wr(3'd1, 32'h0);
    wr(3'd2, 32'h0);
    chk("R6 wrap/unused writes keep request", {31'd0, irq[0]}, 1);
    wr(3'd4, 32'h9000_0000);
    chk("R6 compare write clears", {28'd0, irq}, 0);
  endtask

  task automatic t_collide;
    wr(3'd6, 32'h300);
    wr(3'd0, 32'h2FD);
    tick(3);
    wr(3'd6, 32'h7000_0000);
    chk("R7 match wins over rewrite", {28'd0, irq}, 32'h4);
    tick(2);
    chk("R7 still held", {31'd0, irq[2]}, 1);
    wr(3'd6, 32'h7000_0001);
    chk("R6 later rewrite clears", {31'd0, irq[2]}, 0);
  endtask

  task automatic t_overflow;
    wr(3'd5, 32'h0);
    wr(3'd0, 32'hFFFF_FFFC);
    tick(4);
    chk("R8 not set at zero cycle", {31'd0, irq[1]}, 0);
    tick(1);
    chk("R8 wrap tick on zero compare", {28'd0, irq}, 32'h2);
  endtask

  task automatic t_readback;
    logic [31:0] v;
    rd(3'd4, v); chk("R10 compare 0 readback", v, 32'h9000_0000);
    rd(3'd7, v); chk("R10 compare 3 readback", v, 32'h8000_0003);
    rd(3'd2, v); chk("R10 unused addr 2", v, 0);
    rd(3'd3, v); chk("R10 unused addr 3", v, 0);
  endtask

  task automatic t_rereset;
    logic [31:0] v;
    #0.7 rst_n = 1'b0;
    #0.5;
    chk("R1 async reset clears irq", {28'd0, irq}, 0);
    rd(3'd1, v); chk("R1 async reset clears wrap", v, 0);
    rd(3'd5, v); chk("R1 async reset clears compare", v, 0);
    tick(2);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_count();
    t_match();
    t_collide();
    t_overflow();
    t_readback();
    t_rereset();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule